// File: doc/BRIEF.md
# Fractional-Increment Precision Time Counter

This block is a free-running system time counter for precision time protocol work. On every clock it adds a programmable increment to a 54-bit time value. The time value counts in units of 2^-8 ns. A 32-bit fraction register sits below it, so the increment can carry a sub-nanosecond part. The increment is 42 bits with a least significant bit of 2^-40 ns: the top 10 bits are the coarse part and the low 32 bits are the sub-nanosecond part.

Software-side logic steers the counter through a single adjustment port. A valid strobe and a 2-bit method select choose one of three actions, each taking effect on the following cycle:
- **Coarse set** replaces the whole increment.
- **Fine trim** adds a signed value to the increment and keeps the result.
- **Phase shift** enlarges a single timer step and leaves the stored increment untouched.

An overwrite-capture stage can also load an absolute time value. An optional half-increment flag compensates for a capture that was taken on the opposite clock phase.

Top module: `ptp_tmr_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `timer_o` is 0 and `inc_o` equals the parameter INC_RST (default 42'h100_0000_0000, which is 1 ns).
- R2: With no load, each clock adds `inc_o` to the 86-bit value {timer, 32-bit fraction}. The timer wraps modulo 2^54.
- R3: Method select 2'b00 (coarse) sets `inc_o` to {adj_val_i[9:0], 32'h0} on the next cycle. Bits 31:10 of the value are ignored.
- R4: Method select 2'b01 (fine) adds the sign-extended 32-bit value to the increment, and the result persists. For example, 42'h18D_8AC5_C140 trimmed by 32'hBA9D_1F60 gives 42'h18D_4562_E0A0.
- R5: A fine trim that would go below zero leaves the increment at 0. A fine trim that would exceed 2^42-1 leaves it at 42'h3FF_FFFF_FFFF.
- R6: Method select 2'b10 (phase) makes the timer advance, on the next cycle only, by the increment plus the amount in units of 2^-8 ns. `inc_o` does not change.
- R7: A phase amount above 18'h3_FFFF is clamped to 18'h3_FFFF.
- R8: A load strobe with the half flag low sets `timer_o` to `load_val_i` on the next cycle and clears the fraction. That cycle gets no increment.
- R9: A load strobe with the half flag high sets {timer, fraction} to {load_val_i, 32'h0} + (inc >> 1).
- R10: An adjustment presented in the same cycle as a load is discarded. Method select 2'b11 is ignored. Neither changes `inc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Absolute time load strobe |
| load_half_i | input | 1 | Add half an increment to the loaded value |
| load_val_i | input | 54 | Time value to load (2^-8 ns units) |
| adj_vld_i | input | 1 | Adjustment request strobe |
| adj_sel_i | input | 2 | Method: 00 coarse, 01 fine, 10 phase, 11 none |
| adj_val_i | input | 32 | Adjustment operand |
| timer_o | output | 54 | Current system time (2^-8 ns units) |
| inc_o | output | 42 | Current increment (2^-40 ns units) |

## Verification
Both outputs are registered, so a corrupted increment appears on `inc_o` one cycle after the faulty update. From the next cycle on, it also changes the slope of `timer_o`.

A fraction register that goes wrong stays hidden until it produces a missing or extra carry. With fractional increments, this shows up as a one-unit timer error within a few cycles.

A phase shift that does not expire would add its amount to every step from that point on. A phase shift that is never applied would leave the timer short by the full amount on the very next cycle.

Checking every cycle against a reference model therefore pins each fault to the cycle where it first appears.

// File: rtl/ptp_tmr_pkg.sv
package ptp_tmr_pkg;
  typedef enum logic [1:0] {
    ADJ_COARSE = 2'b00,
    ADJ_FINE   = 2'b01,
    ADJ_PHASE  = 2'b10,
    ADJ_NONE   = 2'b11
  } adj_sel_e;
endpackage

// File: rtl/ptp_inc_ctrl.sv
// Increment register plus one-shot phase amount.
module ptp_inc_ctrl #(
  parameter int          INC_W   = 42,
  parameter int          FRAC_W  = 32,
  parameter int          ADJ_W   = 32,
  parameter int          PH_W    = 18,
  parameter logic [41:0] INC_RST = 42'h100_0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             adj_vld_i,
  input  logic [1:0]       adj_sel_i,
  input  logic [ADJ_W-1:0] adj_val_i,
  output logic [INC_W-1:0] inc_o,
  output logic [PH_W-1:0]  phase_o
);
  import ptp_tmr_pkg::*;

  localparam int CRS_W = INC_W - FRAC_W;
  localparam int SW    = INC_W + 2;
  localparam logic [PH_W-1:0]  PH_MAX  = {PH_W{1'b1}};
  localparam logic [INC_W-1:0] INC_MAX = {INC_W{1'b1}};

  logic [INC_W-1:0] inc_q, inc_d;
  logic [PH_W-1:0]  ph_q, ph_d, ph_clamped;
  logic             accept;
  logic signed [SW-1:0] trim_sum;
  adj_sel_e         sel;

  assign sel    = adj_sel_e'(adj_sel_i);
  assign accept = adj_vld_i && !load_i;

  // saturating fine trim in a two-bit-wider signed domain
  assign trim_sum = $signed({2'b00, inc_q})
                  + $signed({{(SW-ADJ_W){adj_val_i[ADJ_W-1]}}, adj_val_i});

  generate
    if (ADJ_W > PH_W) begin : g_clamp
      assign ph_clamped = (|adj_val_i[ADJ_W-1:PH_W]) ? PH_MAX : adj_val_i[PH_W-1:0];
    end else begin : g_noclamp
      assign ph_clamped = PH_W'(adj_val_i);
    end
  endgenerate

  always_comb begin
    inc_d = inc_q;
    ph_d  = '0;
    if (accept) begin
      unique case (sel)
        ADJ_COARSE: inc_d = {adj_val_i[CRS_W-1:0], {FRAC_W{1'b0}}};
        ADJ_FINE: begin
          if (trim_sum[SW-1])        inc_d = '0;
          else if (trim_sum[SW-2])   inc_d = INC_MAX;
          else                       inc_d = trim_sum[INC_W-1:0];
        end
        ADJ_PHASE:  ph_d = ph_clamped;
        default:    inc_d = inc_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q <= INC_RST[INC_W-1:0];
      ph_q  <= '0;
    end else begin
      inc_q <= inc_d;
      ph_q  <= ph_d;
    end
  end

  assign inc_o   = inc_q;
  assign phase_o = ph_q;
endmodule

// File: rtl/ptp_tmr_acc.sv
// Time value with fractional accumulator underneath.
module ptp_tmr_acc #(
  parameter int TS_W   = 54,
  parameter int FRAC_W = 32,
  parameter int INC_W  = 42,
  parameter int PH_W   = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             half_i,
  input  logic [TS_W-1:0]  load_val_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic [PH_W-1:0]  phase_i,
  output logic [TS_W-1:0]  ts_o
);
  localparam int AW = TS_W + FRAC_W;

  logic [AW-1:0] acc_q, step, load_base, half_add;

  assign step      = AW'(inc_i) + (AW'(phase_i) << FRAC_W);
  assign load_base = {load_val_i, {FRAC_W{1'b0}}};
  assign half_add  = half_i ? AW'(inc_i >> 1) : '0;

  always_ff @(posedge clk) begin
    if (rst)         acc_q <= '0;
    else if (load_i) acc_q <= load_base + half_add;
    else             acc_q <= acc_q + step;
  end

  assign ts_o = acc_q[AW-1:FRAC_W];
endmodule

// File: rtl/ptp_tmr_top.sv
module ptp_tmr_top #(
  parameter int          TS_W    = 54,
  parameter int          INC_W   = 42,
  parameter int          FRAC_W  = 32,
  parameter int          ADJ_W   = 32,
  parameter int          PH_W    = 18,
  parameter logic [41:0] INC_RST = 42'h100_0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             load_half_i,
  input  logic [TS_W-1:0]  load_val_i,
  input  logic             adj_vld_i,
  input  logic [1:0]       adj_sel_i,
  input  logic [ADJ_W-1:0] adj_val_i,
  output logic [TS_W-1:0]  timer_o,
  output logic [INC_W-1:0] inc_o
);
  logic [INC_W-1:0] inc_w;
  logic [PH_W-1:0]  phase_w;

  ptp_inc_ctrl #(
    .INC_W(INC_W), .FRAC_W(FRAC_W), .ADJ_W(ADJ_W), .PH_W(PH_W), .INC_RST(INC_RST)
  ) inc_i (
    .clk(clk), .rst(rst), .load_i(load_i),
    .adj_vld_i(adj_vld_i), .adj_sel_i(adj_sel_i), .adj_val_i(adj_val_i),
    .inc_o(inc_w), .phase_o(phase_w)
  );

  ptp_tmr_acc #(
    .TS_W(TS_W), .FRAC_W(FRAC_W), .INC_W(INC_W), .PH_W(PH_W)
  ) acc_i (
    .clk(clk), .rst(rst), .load_i(load_i), .half_i(load_half_i),
    .load_val_i(load_val_i), .inc_i(inc_w), .phase_i(phase_w),
    .ts_o(timer_o)
  );

  assign inc_o = inc_w;
endmodule

// File: rtl/ptp_tmr_chk.sv
module ptp_tmr_chk #(
  parameter int          TS_W    = 54,
  parameter int          INC_W   = 42,
  parameter int          FRAC_W  = 32,
  parameter int          ADJ_W   = 32,
  parameter int          PH_W    = 18,
  parameter logic [41:0] INC_RST = 42'h100_0000_0000
) (
  input logic             clk,
  input logic             rst,
  input logic             load_i,
  input logic             load_half_i,
  input logic [TS_W-1:0]  load_val_i,
  input logic             adj_vld_i,
  input logic [1:0]       adj_sel_i,
  input logic [ADJ_W-1:0] adj_val_i,
  input logic [TS_W-1:0]  timer_o,
  input logic [INC_W-1:0] inc_o,
  input logic [PH_W-1:0]  phase_amt
);
  localparam logic [PH_W-1:0] PH_MAX = {PH_W{1'b1}};

  logic acc_phase;
  assign acc_phase = adj_vld_i && !load_i && adj_sel_i == 2'b10;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (timer_o == '0 && inc_o == INC_RST[INC_W-1:0]));

  a_r10_inc_hold: assert property (@(posedge clk) disable iff (rst)
    (!adj_vld_i || load_i || adj_sel_i[1]) |=> $stable(inc_o));

  a_r3_coarse_frac_zero: assert property (@(posedge clk) disable iff (rst)
    (adj_vld_i && !load_i && adj_sel_i == 2'b00) |=> inc_o[FRAC_W-1:0] == '0);

  a_r8_load_value: assert property (@(posedge clk) disable iff (rst)
    (load_i && !load_half_i) |=> timer_o == $past(load_val_i));

  a_r6_phase_once: assert property (@(posedge clk) disable iff (rst)
    (phase_amt != '0 && !acc_phase) |=> phase_amt == '0);

  a_r7_phase_clamp: assert property (@(posedge clk) disable iff (rst)
    (acc_phase && (|adj_val_i[ADJ_W-1:PH_W])) |=> phase_amt == PH_MAX);
endmodule

bind ptp_tmr_top ptp_tmr_chk #(
  .TS_W(TS_W), .INC_W(INC_W), .FRAC_W(FRAC_W), .ADJ_W(ADJ_W), .PH_W(PH_W), .INC_RST(INC_RST)
) chk_i (
  .clk(clk), .rst(rst), .load_i(load_i), .load_half_i(load_half_i),
  .load_val_i(load_val_i), .adj_vld_i(adj_vld_i), .adj_sel_i(adj_sel_i),
  .adj_val_i(adj_val_i), .timer_o(timer_o), .inc_o(inc_o), .phase_amt(phase_w)
);

// File: tb/ptp_tmr_top_tb_top.sv
`timescale 1ns/1ps
module ptp_tmr_top_tb_top;
  localparam logic [41:0] INC_RST = 42'h100_0000_0000;

  typedef struct {
    logic [53:0] ts;
    logic [41:0] inc;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_i = 1'b0, load_half_i = 1'b0, adj_vld_i = 1'b0;
  logic [53:0] load_val_i = '0;
  logic [1:0]  adj_sel_i = 2'b11;
  logic [31:0] adj_val_i = '0;
  logic [53:0] timer_o;
  logic [41:0] inc_o;

  int checks = 0, fails = 0;
  bit done = 0;
  item_t q[$];

  logic [85:0] m_acc = '0;
  logic [41:0] m_inc = INC_RST;
  logic [17:0] m_ph = '0;

  always #2.5 clk = ~clk;

  ptp_tmr_top dut_i (
    .clk(clk), .rst(rst), .load_i(load_i), .load_half_i(load_half_i),
    .load_val_i(load_val_i), .adj_vld_i(adj_vld_i), .adj_sel_i(adj_sel_i),
    .adj_val_i(adj_val_i), .timer_o(timer_o), .inc_o(inc_o)
  );

  // Driver: apply one cycle of stimulus and push the expected result.
  task automatic step(input bit r, input bit ld, input bit hf, input logic [53:0] lv,
                      input bit vld, input logic [1:0] sel, input logic [31:0] v,
                      input string tag);
    item_t it;
    logic [17:0] nph;
    logic signed [43:0] s;
    @(negedge clk);
    rst = r; load_i = ld; load_half_i = hf; load_val_i = lv;
    adj_vld_i = vld; adj_sel_i = sel; adj_val_i = v;
    nph = '0;
    if (r) begin
      m_acc = '0; m_inc = INC_RST;
    end else if (ld) begin
      m_acc = {lv, 32'h0} + (hf ? 86'(m_inc >> 1) : 86'd0);
    end else begin
      m_acc = m_acc + 86'(m_inc) + (86'(m_ph) << 32);
      if (vld) begin
        case (sel)
          2'b00: m_inc = {v[9:0], 32'h0};
          2'b01: begin
            s = $signed({2'b00, m_inc}) + $signed({{12{v[31]}}, v});
            if (s < 0) m_inc = '0;
            else if (s > 44'sh3FF_FFFF_FFFF) m_inc = 42'h3FF_FFFF_FFFF;
            else m_inc = s[41:0];
          end
          2'b10: nph = (|v[31:18]) ? 18'h3FFFF : v[17:0];
          default: ;
        endcase
      end
    end
    m_ph = nph;
    it.ts = m_acc[85:32]; it.inc = m_inc; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, 2'b11, '0, tag);
  endtask

  task automatic adj(input logic [1:0] sel, input logic [31:0] v, input string tag);
    step(0, 0, 0, '0, 1, sel, v, tag);
  endtask

  // Monitor: compare after each rising edge.
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (timer_o !== it.ts || inc_o !== it.inc) begin
          fails++;
          $display("FAIL %s: timer=%h inc=%h expected timer=%h inc=%h",
                   it.tag, timer_o, inc_o, it.ts, it.inc);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, '0, 0, 2'b11, '0, "R1 reset");
    step(1, 0, 0, '0, 1, 2'b00, 32'h3FF, "R1 reset");
    idle(4, "R2 free run");
    adj(2'b00, 32'h180, "R3 coarse 1.5ns");
    idle(3, "R2 fractional run");
    adj(2'b00, 32'hFFFF_F18D, "R3 coarse upper ignored");
    adj(2'b01, 32'h4562_E0A0, "R4 fine positive");
    adj(2'b01, 32'h4562_E0A0, "R4 fine positive");
    idle(2, "R2 sub-ns carry");
    adj(2'b01, 32'hBA9D_1F60, "R4 fine negative example");
    idle(3, "R4 persists");
    adj(2'b10, 32'h100, "R6 phase shift");
    idle(3, "R6 one shot");
    adj(2'b10, 32'hFFFF_FFFF, "R7 phase clamp");
    idle(3, "R7 after clamp");
    adj(2'b00, 32'h180, "R3 coarse");
    step(0, 1, 0, 54'h1_2345_6789, 0, 2'b11, '0, "R8 load");
    idle(2, "R8 after load");
    step(0, 1, 1, 54'h2_0000_0000, 0, 2'b11, '0, "R9 half load");
    idle(2, "R9 after half load");
    adj(2'b10, 32'h40, "R6 phase before load");
    step(0, 1, 0, 54'h55, 0, 2'b11, '0, "R8 load drops pending phase");
    step(0, 1, 0, 54'h1000, 1, 2'b00, 32'h3FF, "R10 load beats coarse");
    step(0, 1, 0, 54'h2000, 1, 2'b10, 32'h3FFFF, "R10 load beats phase");
    idle(2, "R10 after");
    adj(2'b11, 32'hFFFF_FFFF, "R10 select 11 ignored");
    idle(2, "R10 after");
    adj(2'b00, 32'h0, "R5 coarse zero");
    adj(2'b01, 32'h8000_0000, "R5 low saturation");
    idle(2, "R5 zero increment");
    adj(2'b00, 32'h3FF, "R5 coarse max");
    adj(2'b01, 32'h7FFF_FFFF, "R5 fine up");
    adj(2'b01, 32'h7FFF_FFFF, "R5 fine up");
    adj(2'b01, 32'h7FFF_FFFF, "R5 high saturation");
    idle(2, "R5 saturated");
    adj(2'b00, 32'h100, "R3 coarse 1ns");
    step(0, 1, 0, 54'h3F_FFFF_FFFF_FFFF, 0, 2'b11, '0, "R2 load near wrap");
    idle(3, "R2 wrap");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule